// File: doc/BRIEF.md
# Load/Store String Register Sequencer

This block moves a run of bytes between memory and a 32-entry register file, one request at a time. A single-cycle start pulse carries the start address, the byte count, the first register index, the direction (load into registers or store from registers), a flag that turns on the overlap check used by the indexed form, the two address-forming register numbers for that check, and a flag that selects 32-bit address arithmetic.

While at least four bytes remain, each step moves one whole 32-bit word, adds 4 to the address and moves on to the next register. Register numbers wrap from 31 back to 0. A trailing group of one to three bytes is moved one byte per step, and the address grows by 1 each time. On a load, the partial register is built left-justified with zeros below the bytes. On a store, the bytes are taken from the top of the register downward. Memory is big-endian: the byte at the lowest address is the most significant byte of a word.

Each memory request is held until the memory side raises ready. Read data must be valid in the same cycle as the handshake. The register file is read combinationally through one port and written on the handshake cycle of a load.

Top module: `strseq_top`

## Requirements
- R1: While four or more bytes remain, each accepted request is a word request. After it, the address is 4 higher and the register index is 1 higher.
- R2: The register index steps from 31 to 0. A run starting at register 30 with 16 bytes uses registers 30, 31, 0 and 1.
- R3: On a load with a trailing 1 to 3 bytes, the last register ends as those bytes placed at bits 31:24, 23:16 and 15:8 in address order, with every lower bit zero.
- R4: On a store with a trailing 1 to 3 bytes, byte requests carry the register's bits 31:24, then 23:16, then 15:8 in mem_req_wdata[7:0], with bits 31:8 zero. The address rises by 1 per byte.
- R5: When start_mode32 is 1, every address increment is truncated to 32 bits, so 0xFFFF_FFFE plus 4 gives 0x2. When it is 0, the carry into bit 32 is kept.
- R6: A byte count of zero issues no memory request and no register write. busy stays low and done pulses on the cycle after start.
- R7: With start_indexed set, the block rejects the operation when the ceil(count/4) registers from start_reg (wrapping) include base_reg (only when base_reg is nonzero) or include index_reg. A rejected operation raises invalid together with a one-cycle done on the cycle after start, and makes no request and no register write.
- R8: busy is high from the cycle after start until the handshake of the last transfer. done is a single-cycle pulse on the cycle after that handshake, and busy is low while done is high.
- R9: A request that is not accepted keeps the same address, kind and direction on the next cycle, and nothing advances.
- R10: A start pulse is ignored while busy or done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle command pulse |
| start_store | input | 1 | 1 = registers to memory, 0 = memory to registers |
| start_indexed | input | 1 | Enables the register overlap check |
| start_mode32 | input | 1 | Truncate address increments to 32 bits |
| start_addr | input | ADDR_W | First byte address |
| start_count | input | CNT_W | Number of bytes to move |
| start_reg | input | 5 | First register index |
| base_reg | input | 5 | Base register number for the overlap check (0 exempt) |
| index_reg | input | 5 | Index register number for the overlap check |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Request is a write |
| mem_req_word | output | 1 | 1 = 32-bit word, 0 = single byte |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_wdata | output | 32 | Write data (byte in bits 7:0) |
| mem_rdata | input | 32 | Read data, valid on the handshake cycle (byte in bits 7:0) |
| rf_addr | output | 5 | Register file index |
| rf_we | output | 1 | Register write enable |
| rf_wdata | output | 32 | Register write data |
| rf_rdata | input | 32 | Register read data for rf_addr |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| invalid | output | 1 | Overlap rejection, coincident with done |

## Verification
Both directions are swept over every byte count from 0 to 17, from start registers 0 and 29, with ready held high and with a periodic stall. This separates the pure-word runs from the runs with 1, 2 or 3 trailing bytes, and shows register wrap and held requests. Address sequences start just below the 4 GiB boundary in both address modes, so truncation is told apart from carry. Overlap cases place the base and index registers inside and outside the written range, including base register 0, so each leg of the reject rule is tested on its own.

// File: rtl/strseq_pkg.sv
package strseq_pkg;

    localparam int REG_IDX_W = 5;
    localparam int WORD_W    = 32;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_MOVE,
        SQ_FIN
    } sq_state_e;

    typedef struct packed {
        logic store;
        logic mode32;
        logic reject;
    } sq_ctl_t;

    // Bit offset of a trailing byte within the word: 24, 16, 8.
    function automatic logic [4:0] lane_shift(input logic [1:0] lane);
        return 5'(5'd24 - {lane, 3'b000});
    endfunction

endpackage

// File: rtl/strseq_addr_step.sv
module strseq_addr_step #(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [2:0]        incr,
    input  logic              mode32,
    output logic [ADDR_W-1:0] addr_out
);
    logic [ADDR_W-1:0] sum;

    assign sum = addr_in + ADDR_W'(incr);

    generate
        if (ADDR_W > 32) begin : g_wide
            assign addr_out = mode32 ? {{(ADDR_W-32){1'b0}}, sum[31:0]} : sum;
        end else begin : g_narrow
            logic unused_mode;
            assign unused_mode = mode32;
            assign addr_out = sum;
        end
    endgenerate
endmodule

// File: rtl/strseq_overlap.sv
module strseq_overlap #(
    parameter int CNT_W = 7
) (
    input  logic             check_en,
    input  logic [CNT_W-1:0] count,
    input  logic [4:0]       first_reg,
    input  logic [4:0]       base_reg,
    input  logic [4:0]       index_reg,
    output logic             reject
);
    localparam int NW = (CNT_W + 1 > 6) ? CNT_W + 1 : 6;

    logic [NW-1:0] nregs;
    logic [4:0]    dist_base, dist_index;
    logic          hit_base, hit_index;

    assign nregs      = NW'((NW'(count) + NW'(3)) >> 2);
    assign dist_base  = base_reg - first_reg;
    assign dist_index = index_reg - first_reg;
    assign hit_base   = (base_reg != 5'd0) && (NW'(dist_base) < nregs);
    assign hit_index  = NW'(dist_index) < nregs;
    assign reject     = check_en && (count != '0) && (hit_base || hit_index);
endmodule

// File: rtl/strseq_lane.sv
module strseq_lane
    import strseq_pkg::*;
(
    input  logic        word,
    input  logic [1:0]  lane,
    input  logic [31:0] mem_rdata,
    input  logic [31:0] rf_rdata,
    input  logic [31:0] acc,
    output logic [31:0] mem_wdata,
    output logic [31:0] rf_wdata
);
    logic [4:0]  sh;
    logic [31:0] base_val;

    assign sh       = lane_shift(lane);
    assign base_val = (lane == 2'd0) ? 32'h0 : acc;

    always_comb begin
        if (word) begin
            rf_wdata  = mem_rdata;
            mem_wdata = rf_rdata;
        end else begin
            rf_wdata  = base_val | (32'(mem_rdata[7:0]) << sh);
            mem_wdata = {24'h0, 8'(rf_rdata >> sh)};
        end
    end
endmodule

// File: rtl/strseq_top.sv
module strseq_top
    import strseq_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_store,
    input  logic              start_indexed,
    input  logic              start_mode32,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  start_count,
    input  logic [4:0]        start_reg,
    input  logic [4:0]        base_reg,
    input  logic [4:0]        index_reg,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic              mem_req_word,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [31:0]       mem_req_wdata,
    input  logic [31:0]       mem_rdata,
    output logic [4:0]        rf_addr,
    output logic              rf_we,
    output logic [31:0]       rf_wdata,
    input  logic [31:0]       rf_rdata,
    output logic              busy,
    output logic              done,
    output logic              invalid
);
    sq_state_e         st;
    sq_ctl_t           ctl;
    logic [ADDR_W-1:0] cur_addr, next_addr;
    logic [CNT_W-1:0]  remain, remain_next;
    logic [4:0]        cur_reg;
    logic [1:0]        lane;
    logic [31:0]       acc;
    logic              is_word, hs, reject;

    assign is_word     = remain >= CNT_W'(4);
    assign hs          = (st == SQ_MOVE) && mem_req_ready;
    assign remain_next = remain - (is_word ? CNT_W'(4) : CNT_W'(1));

    strseq_addr_step #(.ADDR_W(ADDR_W)) u_step (
        .addr_in (cur_addr),
        .incr    (is_word ? 3'd4 : 3'd1),
        .mode32  (ctl.mode32),
        .addr_out(next_addr)
    );

    strseq_overlap #(.CNT_W(CNT_W)) u_ovl (
        .check_en (start_indexed),
        .count    (start_count),
        .first_reg(start_reg),
        .base_reg (base_reg),
        .index_reg(index_reg),
        .reject   (reject)
    );

    strseq_lane u_lane (
        .word     (is_word),
        .lane     (lane),
        .mem_rdata(mem_rdata),
        .rf_rdata (rf_rdata),
        .acc      (acc),
        .mem_wdata(mem_req_wdata),
        .rf_wdata (rf_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SQ_IDLE;
            ctl      <= '0;
            cur_addr <= '0;
            remain   <= '0;
            cur_reg  <= '0;
            lane     <= '0;
            acc      <= '0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (start) begin
                        ctl.store  <= start_store;
                        ctl.mode32 <= start_mode32;
                        ctl.reject <= reject;
                        cur_addr   <= start_addr;
                        remain     <= start_count;
                        cur_reg    <= start_reg;
                        lane       <= 2'd0;
                        acc        <= '0;
                        st         <= (reject || start_count == '0) ? SQ_FIN : SQ_MOVE;
                    end
                end
                SQ_MOVE: begin
                    if (hs) begin
                        cur_addr <= next_addr;
                        remain   <= remain_next;
                        acc      <= rf_wdata;
                        if (is_word) cur_reg <= cur_reg + 5'd1;
                        else         lane    <= lane + 2'd1;
                        if (remain_next == '0) st <= SQ_FIN;
                    end
                end
                default: begin
                    st         <= SQ_IDLE;
                    ctl.reject <= 1'b0;
                end
            endcase
        end
    end

    assign mem_req_valid = (st == SQ_MOVE);
    assign mem_req_write = ctl.store;
    assign mem_req_word  = is_word;
    assign mem_req_addr  = cur_addr;
    assign rf_addr       = cur_reg;
    assign rf_we         = hs && !ctl.store;
    assign busy          = (st == SQ_MOVE);
    assign done          = (st == SQ_FIN);
    assign invalid       = (st == SQ_FIN) && ctl.reject;
endmodule

// File: rtl/strseq_chk.sv
module strseq_chk #(
    parameter int ADDR_W = 64,
    parameter int CNT_W  = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [CNT_W-1:0]  start_count,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic              mem_req_word,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [31:0]       mem_req_wdata,
    input logic [4:0]        rf_addr,
    input logic              rf_we,
    input logic              busy,
    input logic              done,
    input logic              invalid
);
    // R1
    word_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_ready && mem_req_word) |=>
            (!mem_req_valid || rf_addr == $past(rf_addr) + 5'd1));

    // R4
    byte_store_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write && !mem_req_word) |-> (mem_req_wdata[31:8] == 24'h0));

    // R6
    zero_count_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !done && start_count == '0) |=> (done && !busy && !mem_req_valid));

    // R7
    invalid_done_chk: assert property (@(posedge clk) disable iff (rst)
        invalid |-> (done && !rf_we && !mem_req_valid));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_word)
             && $stable(mem_req_write) && $stable(rf_addr)));
endmodule

bind strseq_top strseq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .start_count(start_count),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_word(mem_req_word),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .rf_addr(rf_addr), .rf_we(rf_we), .busy(busy), .done(done), .invalid(invalid)
);

// File: tb/tb_strseq_top.sv
module tb_strseq_top;
    localparam int ADDR_W = 64;
    localparam int CNT_W  = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic              start = 0, start_store = 0, start_indexed = 0, start_mode32 = 0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [CNT_W-1:0]  start_count = '0;
    logic [4:0]        start_reg = '0, base_reg = '0, index_reg = '0;
    logic              mem_req_valid, mem_req_write, mem_req_word;
    logic              mem_req_ready = 1'b1;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [31:0]       mem_req_wdata, mem_rdata, rf_wdata, rf_rdata;
    logic [4:0]        rf_addr;
    logic              rf_we, busy, done, invalid;

    strseq_top #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (.*);

    logic [7:0]  mem [256];
    logic [31:0] rf  [32];
    logic [7:0]  mem_exp [256];
    logic [31:0] rf_exp  [32];
    logic [ADDR_W-1:0] log_addr [64];
    logic [31:0] log_wdata [64];
    int n_hs;
    int tests = 0, fails = 0;
    logic stall_en = 0;
    int cyc = 0;

    // memory and register file models
    always_comb begin
        logic [7:0] a;
        a = mem_req_addr[7:0];
        if (mem_req_word) mem_rdata = {mem[a], mem[8'(a+1)], mem[8'(a+2)], mem[8'(a+3)]};
        else              mem_rdata = {24'h0, mem[a]};
    end
    assign rf_rdata = rf[rf_addr];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rf_we) rf[rf_addr] <= rf_wdata;
        if (mem_req_valid && mem_req_ready && mem_req_write) begin
            if (mem_req_word) begin
                mem[mem_req_addr[7:0]]         <= mem_req_wdata[31:24];
                mem[8'(mem_req_addr[7:0] + 1)] <= mem_req_wdata[23:16];
                mem[8'(mem_req_addr[7:0] + 2)] <= mem_req_wdata[15:8];
                mem[8'(mem_req_addr[7:0] + 3)] <= mem_req_wdata[7:0];
            end else begin
                mem[mem_req_addr[7:0]] <= mem_req_wdata[7:0];
            end
        end
    end

    // ready pattern, changed away from the edge
    always @(posedge clk) begin
        #2 mem_req_ready <= stall_en ? ((cyc % 3) != 1) : 1'b1;
    end

    // handshake log
    always @(negedge clk) begin
        if (mem_req_valid && mem_req_ready && n_hs < 64) begin
            log_addr[n_hs]  <= mem_req_addr;
            log_wdata[n_hs] <= mem_req_wdata;
            n_hs <= n_hs + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] add_addr(input logic [ADDR_W-1:0] a, input int inc, input bit m32);
        logic [ADDR_W-1:0] s;
        s = a + ADDR_W'(inc);
        if (m32) s = {32'h0, s[31:0]};
        return s;
    endfunction

    task automatic run_op(input bit st, input logic [ADDR_W-1:0] addr, input int cnt,
                          input int r0, input bit idx, input int b, input int x,
                          input bit m32, input bit exp_rej, input string req);
        logic [ADDR_W-1:0] ea [64];
        int ne = 0;
        int rem = cnt;
        logic [ADDR_W-1:0] a = addr;
        int wait_cyc = 0;
        bit inv_seen = 0;
        bit ok;
        int bad = 0;
        for (int i = 0; i < 256; i++) mem_exp[i] = mem[i];
        for (int i = 0; i < 32; i++) rf_exp[i] = rf[i];
        if (!exp_rej) begin
            for (int k = 0; k < cnt; k++) begin
                int rr = (r0 + k / 4) % 32;
                int sh = 24 - 8 * (k % 4);
                logic [7:0] ab = 8'(addr[7:0] + k);
                if (st) mem_exp[ab] = 8'(rf[rr] >> sh);
                else begin
                    if (k % 4 == 0) rf_exp[rr] = 32'h0;
                    rf_exp[rr] = rf_exp[rr] | (32'(mem[ab]) << sh);
                end
            end
            while (rem > 0) begin
                ea[ne] = a; ne++;
                if (rem >= 4) begin a = add_addr(a, 4, m32); rem -= 4; end
                else begin a = add_addr(a, 1, m32); rem -= 1; end
            end
        end
        @(negedge clk);
        n_hs = 0;
        start = 1; start_store = st; start_addr = addr; start_count = CNT_W'(cnt);
        start_reg = 5'(r0); start_indexed = idx; base_reg = 5'(b); index_reg = 5'(x);
        start_mode32 = m32;
        @(negedge clk);
        start = 0;
        // R8: busy rises the cycle after start; R6/R7: otherwise done at once
        if (exp_rej || cnt == 0)
            check(!busy && done && (invalid == exp_rej), exp_rej ? "R7" : "R6",
                  "immediate done/invalid", {busy, done, invalid}, {1'b0, 1'b1, exp_rej});
        else
            check(busy && !done, "R8", "busy after start", {busy, done}, 2'b10);
        while (!done && wait_cyc < 300) begin
            @(negedge clk);
            wait_cyc++;
        end
        inv_seen = invalid;
        check(done, "R8", "done reached (watchdog)", 64'(done), 64'd1);
        @(negedge clk);
        check(!done && !busy, "R8", "done is one cycle", {busy, done}, 2'b00);
        check(inv_seen == exp_rej, "R7", "invalid flag", 64'(inv_seen), 64'(exp_rej));
        check(n_hs == ne, req, "request count", 64'(n_hs), 64'(ne));
        ok = 1;
        for (int i = 0; i < ne && i < n_hs; i++) if (log_addr[i] != ea[i]) begin
            if (ok) check(0, req, "address sequence", log_addr[i], ea[i]);
            ok = 0;
        end
        if (ok && ne > 0) check(1, req, "address sequence", 0, 0);
        for (int i = 0; i < 32; i++) if (rf[i] != rf_exp[i]) begin
            if (bad == 0) check(0, req, $sformatf("register %0d", i), rf[i], rf_exp[i]);
            bad++;
        end
        for (int i = 0; i < 256; i++) if (mem[i] != mem_exp[i]) begin
            if (bad == 0) check(0, req, $sformatf("memory byte %0d", i), mem[i], mem_exp[i]);
            bad++;
        end
        if (bad == 0) check(1, req, "data", 0, 0);
    endtask

    initial begin
        #1400000;
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) ^ 8'h5A);
        for (int i = 0; i < 32; i++)  rf[i]  = 32'hDEAD_0000 + 32'(i) * 32'h0101;
        n_hs = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!busy && !done && !invalid && !mem_req_valid && !rf_we, "R8", "reset state",
              {busy, done, invalid, mem_req_valid, rf_we}, 5'b0);

        // R1 R2 R3 R4 R6 R9: sweep of counts, start registers, direction, stalls
        for (int s = 0; s < 2; s++)
            for (int d = 0; d < 2; d++)
                for (int r = 0; r < 2; r++)
                    for (int c = 0; c <= 17; c++) begin
                        stall_en = s[0];
                        run_op(d[0], 64'h40 + 64'(c), c, r ? 29 : 0, 0, 0, 0, 0, 0,
                               c == 0 ? "R6" : (c % 4 != 0 ? (d ? "R4" : "R3")
                                                : (r ? "R2" : (s ? "R9" : "R1"))));
                    end
        stall_en = 0;

        // R2: 16 bytes from register 30 use 30, 31, 0, 1
        run_op(0, 64'h80, 16, 30, 0, 0, 0, 0, 0, "R2");

        // R5: address wrap in 32-bit mode, carry in 64-bit mode
        run_op(0, 64'hFFFF_FFFE, 7, 3, 0, 0, 0, 1, 0, "R5");
        run_op(1, 64'hFFFF_FFFD, 6, 8, 0, 0, 0, 1, 0, "R5");
        run_op(0, 64'hFFFF_FFFE, 7, 3, 0, 0, 0, 0, 0, "R5");

        // R7: overlap rule; regs written 30,31,0 for 9 bytes from 30
        run_op(0, 64'h10, 9, 30, 1, 0, 5, 0, 0, "R7");
        run_op(0, 64'h10, 9, 30, 1, 0, 0, 0, 1, "R7");
        run_op(0, 64'h10, 9, 30, 1, 31, 5, 0, 1, "R7");
        run_op(0, 64'h10, 9, 30, 1, 1, 2, 0, 0, "R7");
        run_op(1, 64'h10, 9, 30, 1, 5, 30, 0, 1, "R7");
        run_op(0, 64'h10, 0, 30, 1, 0, 30, 0, 0, "R6");

        // R10: a start while busy is ignored
        stall_en = 1;
        @(negedge clk);
        n_hs = 0;
        for (int i = 0; i < 32; i++) rf_exp[i] = rf[i];
        start = 1; start_store = 0; start_addr = 64'h20; start_count = 7'd8;
        start_reg = 5'd12; start_indexed = 0; start_mode32 = 0;
        @(negedge clk);
        start_addr = 64'h90; start_reg = 5'd20; start_count = 7'd4;
        @(negedge clk);
        start = 0;
        while (!done) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check(n_hs == 2 && rf[20] == rf_exp[20], "R10", "second start ignored",
              {32'(n_hs), rf[20]}, {32'd2, rf_exp[20]});
        check(rf[12] == {mem[8'h20], mem[8'h21], mem[8'h22], mem[8'h23]}, "R10",
              "first command completed", rf[12], {mem[8'h20], mem[8'h21], mem[8'h22], mem[8'h23]});
        stall_en = 0;

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule